// File: doc/BRIEF.md
# Vector-Programmed Receive Word Packer

This block takes bits, one per accepted cycle, from a protocol deserializer. It collects them into 32-bit entries that it writes to a receive FIFO. Four packing vectors set where the bits go. Each vector describes one operation: the entry bit position where its run starts, whether the run climbs or descends from that position, how many bits it covers (one to eight), and whether the entry is finished once the run is done. The vectors run in order 0, 1, 2, 3. An operation that ends the entry sends the assembled word to the FIFO port and starts a fresh, all-zero entry.

A flush marker that arrives with a bit closes the partial entry early. A valid/ready pair at the FIFO side holds the serial input off while a finished entry waits to be taken. A 2-bit granularity code, which gives the number of protocol words per entry, is normalised and reported back.

Top module: `rx_vec_packer`

## Requirements
- R1: Each 10-bit vector holds a stop flag at bit 0, the run length minus one at bits 3:1, a direction flag at bit 4 and a start position at bits 9:5. Configuration word 0 carries vector 0 in bits 9:0 and vector 1 in bits 19:10. Configuration word 1 carries vectors 2 and 3 in the same places.
- R2: The k-th bit of an operation (k counted from 0) lands at entry position (start + k) mod 32 when the direction flag is 0, and at (start - k) mod 32 when it is 1.
- R3: An operation takes exactly length-minus-one plus one bits. The bit after that belongs to the next vector.
- R4: The bit that finishes an operation whose stop flag is set also finishes the entry, and the next bit is handled by vector 0 at k = 0.
- R5: The bit that finishes vector 3 finishes the entry even when vector 3 has no stop flag.
- R6: Entry bits that no operation wrote since the previous entry read as 0.
- R7: While an entry is offered (`fifo_valid` = 1), `ser_ready` is 0 and `fifo_data` holds steady until `fifo_ready` is seen high. The entry appears on the port in the cycle after its last bit is accepted.
- R8: A bit accepted with `ser_last` = 1 is written into the entry first, and then the entry is emitted at once. Packing restarts at vector 0, k = 0.
- R9: `gran_out` equals `gran_in` for codes 0 (four words per entry), 1 (two words) and 2 (one word). Code 3 is reported as 2.
- R10: While `rst` is high and in the cycle after it, `fifo_valid` is 0 and `ser_ready` is 1. The partial entry and the vector position are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_valid | input | 1 | A serial bit is offered |
| ser_bit | input | 1 | The serial bit value |
| ser_last | input | 1 | Flush: close the entry after this bit |
| ser_ready | output | 1 | A bit is accepted when ser_valid and ser_ready are both high |
| pack_cfg0 | input | 20 | Vectors 0 and 1 |
| pack_cfg1 | input | 20 | Vectors 2 and 3 |
| gran_in | input | 2 | Granularity code |
| gran_out | output | 2 | Normalised granularity code |
| fifo_valid | output | 1 | An entry is offered to the FIFO |
| fifo_data | output | 32 | Entry data |
| fifo_ready | input | 1 | The FIFO takes the entry |

## Verification
The checks on run lengths and on the vector position assume that `pack_cfg0` and `pack_cfg1` change only while no entry is partly assembled, that is, between entries. The stimulus therefore reprograms the vectors only after the previous entry has left the FIFO port. The serial side is assumed to keep its bit offered until it sees `ser_ready`. The bench drives bits only when ready is high and removes them right after the accepting edge. Stalls on the FIFO side are placed at arbitrary points, including while bits are waiting.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    localparam int ENTRY_W  = 32;
    localparam int VEC_W    = 10;
    localparam int NUM_VEC  = 4;
    localparam int POS_W    = $clog2(ENTRY_W);
    localparam int LEN_W    = 3;
    localparam int IDX_W    = $clog2(NUM_VEC);
    localparam int CFG_W    = 2 * VEC_W;

    // bit layout matters: start 9:5, dir 4, len-1 3:1, stop 0
    typedef struct packed {
        logic [POS_W-1:0] start;
        logic             dir;
        logic [LEN_W-1:0] len_m1;
        logic             stop;
    } pack_vec_t;

    typedef enum logic [1:0] {
        GRAN_4X8  = 2'd0,
        GRAN_2X16 = 2'd1,
        GRAN_1X32 = 2'd2,
        GRAN_RSVD = 2'd3
    } gran_e;

    function automatic gran_e gran_norm(input logic [1:0] code);
        gran_e g;
        g = gran_e'(code);
        if (g == GRAN_RSVD) g = GRAN_1X32;
        return g;
    endfunction

    function automatic logic [POS_W-1:0] run_pos(input pack_vec_t v,
                                                 input logic [LEN_W-1:0] k);
        logic [POS_W-1:0] kk;
        kk = POS_W'(k);
        return v.dir ? (v.start - kk) : (v.start + kk);
    endfunction

endpackage

// File: rtl/rxpk_vec_sel.sv
module rxpk_vec_sel
    import rxpk_pkg::*;
(
    input  logic [CFG_W-1:0]  cfg0,
    input  logic [CFG_W-1:0]  cfg1,
    input  logic [IDX_W-1:0]  idx,
    output pack_vec_t         vec
);
    localparam int PER_WORD = CFG_W / VEC_W;

    pack_vec_t vecs [NUM_VEC];

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_unpack
        if (g < PER_WORD) begin : g_w0
            assign vecs[g] = pack_vec_t'(cfg0[g*VEC_W +: VEC_W]);
        end else begin : g_w1
            assign vecs[g] = pack_vec_t'(cfg1[(g-PER_WORD)*VEC_W +: VEC_W]);
        end
    end

    assign vec = vecs[idx];

endmodule

// File: rtl/rxpk_seq.sv
module rxpk_seq
    import rxpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pack_vec_t         vec,
    input  logic              accept,
    input  logic              last,
    output logic [IDX_W-1:0]  idx,
    output logic [POS_W-1:0]  pos,
    output logic              close_entry
);
    logic [LEN_W-1:0] cnt;
    logic             op_done;

    assign op_done     = (cnt == vec.len_m1);
    assign pos         = run_pos(vec, cnt);
    assign close_entry = accept &&
                         (last || (op_done && (vec.stop || idx == IDX_W'(NUM_VEC-1))));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            cnt <= '0;
        end else if (accept) begin
            if (close_entry) begin
                idx <= '0;
                cnt <= '0;
            end else if (op_done) begin
                idx <= idx + 1'b1;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        accept && !close_entry && !op_done |=> cnt != '0) else $error("cnt");   // R3
    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        close_entry |=> (idx == '0 && cnt == '0)) else $error("restart");      // R4

endmodule

// File: rtl/rxpk_entry.sv
module rxpk_entry
    import rxpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_valid,
    input  logic               ser_bit,
    input  logic [POS_W-1:0]   pos,
    input  logic               close_entry,
    input  logic               fifo_ready,
    output logic               accept,
    output logic               ser_ready,
    output logic               fifo_valid,
    output logic [ENTRY_W-1:0] fifo_data
);
    logic [ENTRY_W-1:0] partial;
    logic [ENTRY_W-1:0] partial_nxt;

    assign ser_ready = !fifo_valid;
    assign accept    = ser_valid && ser_ready;

    always_comb begin
        partial_nxt      = partial;
        partial_nxt[pos] = ser_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            partial    <= '0;
            fifo_valid <= 1'b0;
            fifo_data  <= '0;
        end else if (accept) begin
            if (close_entry) begin
                fifo_data  <= partial_nxt;
                fifo_valid <= 1'b1;
                partial    <= '0;
            end else begin
                partial    <= partial_nxt;
            end
        end else if (fifo_valid && fifo_ready) begin
            fifo_valid <= 1'b0;
        end
    end

    AST_NO_ACCEPT_WHILE_OFFERED: assert property (@(posedge clk) disable iff (rst)
        fifo_valid |-> !ser_ready) else $error("ready");                       // R7
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
        fifo_valid && !fifo_ready |=> fifo_valid && $stable(fifo_data)) else $error("hold"); // R7
    AST_OFFER_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_valid) |-> $past(ser_valid)) else $error("rose");          // R4

endmodule

// File: rtl/rx_vec_packer.sv
module rx_vec_packer
    import rxpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_valid,
    input  logic               ser_bit,
    input  logic               ser_last,
    output logic               ser_ready,
    input  logic [CFG_W-1:0]   pack_cfg0,
    input  logic [CFG_W-1:0]   pack_cfg1,
    input  logic [1:0]         gran_in,
    output logic [1:0]         gran_out,
    output logic               fifo_valid,
    output logic [ENTRY_W-1:0] fifo_data,
    input  logic               fifo_ready
);
    pack_vec_t        cur_vec;
    logic [IDX_W-1:0] idx;
    logic [POS_W-1:0] pos;
    logic             close_entry;
    logic             accept;

    assign gran_out = gran_norm(gran_in);

    rxpk_vec_sel u_sel (
        .cfg0 (pack_cfg0),
        .cfg1 (pack_cfg1),
        .idx  (idx),
        .vec  (cur_vec)
    );

    rxpk_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .vec         (cur_vec),
        .accept      (accept),
        .last        (ser_last),
        .idx         (idx),
        .pos         (pos),
        .close_entry (close_entry)
    );

    rxpk_entry u_entry (
        .clk         (clk),
        .rst         (rst),
        .ser_valid   (ser_valid),
        .ser_bit     (ser_bit),
        .pos         (pos),
        .close_entry (close_entry),
        .fifo_ready  (fifo_ready),
        .accept      (accept),
        .ser_ready   (ser_ready),
        .fifo_valid  (fifo_valid),
        .fifo_data   (fifo_data)
    );

    AST_GRAN_NO_RSVD: assert property (@(posedge clk)
        gran_out != 2'd3) else $error("gran");                                // R9
    AST_FLUSH_EMITS: assert property (@(posedge clk) disable iff (rst)
        ser_valid && ser_ready && ser_last |=> fifo_valid) else $error("flush"); // R8
    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !fifo_valid && ser_ready) else $error("reset");        // R10

endmodule

// File: tb/test_rx_vec_packer.sv
module test_rx_vec_packer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_valid = 1'b0, ser_bit = 1'b0, ser_last = 1'b0;
    logic        ser_ready;
    logic [19:0] pack_cfg0 = '0, pack_cfg1 = '0;
    logic [1:0]  gran_in = 2'd0, gran_out;
    logic        fifo_valid, fifo_ready = 1'b1;
    logic [31:0] fifo_data;

    int total = 0, bad = 0, wd = 0;
    logic [31:0] got_q [$];

    // model state
    logic        m_valid;
    logic [31:0] m_data, m_asm;
    int          m_idx, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_vec_packer i_rx_vec_packer (
        .clk(clk), .rst(rst), .ser_valid(ser_valid), .ser_bit(ser_bit),
        .ser_last(ser_last), .ser_ready(ser_ready), .pack_cfg0(pack_cfg0),
        .pack_cfg1(pack_cfg1), .gran_in(gran_in), .gran_out(gran_out),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model, behavioural
    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_data = 0; m_asm = 0; m_idx = 0; m_cnt = 0;
        end else begin
            bit acc;
            int vec, st, ln, pos;
            bit dr, sp;
            acc = ser_valid && !m_valid;
            if (m_valid && fifo_ready) m_valid = 0;
            if (acc) begin
                vec = (m_idx < 2) ? int'((pack_cfg0 >> (10*m_idx)) & 20'h3FF)
                                  : int'((pack_cfg1 >> (10*(m_idx-2))) & 20'h3FF);
                st = (vec >> 5) & 31; dr = vec[4]; ln = (vec >> 1) & 7; sp = vec[0];
                pos = dr ? ((st - m_cnt) & 31) : ((st + m_cnt) & 31);
                m_asm[pos] = ser_bit;
                if (ser_last || (m_cnt == ln && (sp || m_idx == 3))) begin
                    m_data = m_asm; m_valid = 1; m_asm = 0; m_idx = 0; m_cnt = 0;
                end else if (m_cnt == ln) begin
                    m_idx++; m_cnt = 0;
                end else m_cnt++;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R7 fifo_valid", {31'd0, fifo_valid}, {31'd0, m_valid});
            check("R7 ser_ready", {31'd0, ser_ready}, {31'd0, !m_valid});
            if (m_valid) check("R2 fifo_data", fifo_data, m_data);
            check("R9 gran_out", {30'd0, gran_out},
                  {30'd0, (gran_in == 2'd3) ? 2'd2 : gran_in});
            if (fifo_valid && fifo_ready) got_q.push_back(fifo_data);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send_bit(input logic b, input logic last);
        @(negedge clk);
        while (!ser_ready) @(negedge clk);
        ser_valid = 1'b1; ser_bit = b; ser_last = last;
        @(posedge clk);
        #1 ser_valid = 1'b0; ser_last = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w, input int n, input bit msb_first,
                             input bit last_on_end);
        for (int i = 0; i < n; i++) begin
            int b;
            b = msb_first ? n-1-i : i;
            send_bit(w[b], last_on_end && (i == n-1));
        end
    endtask

    task automatic expect_entry(input string tag, input logic [31:0] exp);
        repeat (3) @(negedge clk);
        if (got_q.size() == 0) check(tag, 32'hDEAD_DEAD, exp);
        else check(tag, got_q.pop_front(), exp);
    endtask

    function automatic logic [9:0] mkv(input int st, input bit dr, input int len, input bit sp);
        return 10'((st << 5) | (int'(dr) << 4) | ((len-1) << 1) | int'(sp));
    endfunction

    initial begin
        logic [31:0] a, b;
        logic [6:0]  w7 [4];
        repeat (3) @(negedge clk);
        check("R10 ready in reset", {31'd0, ser_ready}, 32'd1);
        check("R10 valid in reset", {31'd0, fifo_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 ready after reset", {31'd0, ser_ready}, 32'd1);

        // R1 R3 two 15-bit words, LSB first
        pack_cfg0 = {mkv(8,0,7,0), mkv(0,0,8,0)};
        pack_cfg1 = {mkv(24,0,7,1), mkv(16,0,8,0)};
        a = 32'h5A3C; b = 32'h1234;
        send_word(a, 15, 0, 0); send_word(b, 15, 0, 0);
        expect_entry("R1 R3 two-by-16", {1'b0, b[14:0], 1'b0, a[14:0]});

        // R2 R6 four 7-bit words MSB first
        pack_cfg0 = {mkv(14,1,7,0), mkv(6,1,7,0)};
        pack_cfg1 = {mkv(30,1,7,1), mkv(22,1,7,0)};
        w7[0] = 7'h55; w7[1] = 7'h7F; w7[2] = 7'h01; w7[3] = 7'h2A;
        for (int i = 0; i < 4; i++) send_word({25'd0, w7[i]}, 7, 1, 0);
        expect_entry("R2 R6 four-by-8", {1'b0, w7[3], 1'b0, w7[2], 1'b0, w7[1], 1'b0, w7[0]});

        // R4 stop on vector 2, 23-bit word MSB first
        pack_cfg0 = {mkv(14,1,8,0), mkv(22,1,8,0)};
        pack_cfg1 = {10'h000, mkv(6,1,7,1)};
        a = 32'h5B_C3A1;
        send_word(a, 23, 1, 0);
        expect_entry("R4 one-by-32 stop", {9'd0, a[22:0]});
        b = 32'h12_3456;
        send_word(b, 23, 1, 0);
        expect_entry("R4 restart at vector 0", {9'd0, b[22:0]});

        // R5 no stop flags: closes after vector 3
        pack_cfg0 = {mkv(8,0,8,0), mkv(0,0,8,0)};
        pack_cfg1 = {mkv(24,0,8,0), mkv(16,0,8,0)};
        a = 32'hCAFE_F00D;
        send_word(a, 32, 0, 0);
        expect_entry("R5 close after vector 3", a);

        // R8 flush after 5 bits
        send_word(32'h1B, 5, 0, 1);
        expect_entry("R8 flush partial", 32'h0000_001B);
        send_word(32'h0F0F_0F0F, 32, 0, 0);
        expect_entry("R8 restart after flush", 32'h0F0F_0F0F);

        // R2 wrap past position 31
        pack_cfg0 = {10'h000, mkv(30,0,4,1)};
        send_word(32'hF, 4, 0, 0);
        expect_entry("R2 wrap", 32'hC000_0003);

        // R7 back-pressure while bits wait
        pack_cfg0 = {mkv(8,0,8,0), mkv(0,0,8,0)};
        pack_cfg1 = {mkv(24,0,8,0), mkv(16,0,8,0)};
        fifo_ready = 1'b0;
        fork
            begin send_word(32'hA5A5_0001, 32, 0, 0); send_word(32'h0000_00FF, 8, 0, 1); end
            begin
                repeat (45) @(negedge clk);
                check("R7 held while stalled", fifo_data, 32'hA5A5_0001);
                check("R7 ready low while stalled", {31'd0, ser_ready}, 32'd0);
                fifo_ready = 1'b1;
            end
        join
        expect_entry("R7 stalled entry", 32'hA5A5_0001);
        expect_entry("R8 flush after stall", 32'h0000_00FF);

        // R9 granularity codes
        for (int g = 0; g < 4; g++) begin
            gran_in = 2'(g);
            @(negedge clk);
            check("R9 gran", {30'd0, gran_out}, (g == 3) ? 32'd2 : 32'(g));
        end

        // R10 reset mid-entry clears partial
        send_word(32'h7, 3, 0, 0);
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        send_word(32'h1, 1, 0, 1);
        expect_entry("R10 partial cleared", 32'h0000_0001);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule